// File: doc/BRIEF.md
# Periodic Timing Pulse and Interrupt Output

This block is the periodic-event stage of a real-time clock. A one-cycle timebase enable (`tick`, nominally 32.768 kHz) advances a prescaler chain that produces events at one of four rates. At each event the block raises an interrupt flag and, unless masked, pulls an open-drain output low. The output-enable `pin_drive_low` is active high, and `pin_level` gives the resulting pad level when the pad has a pull-up.

Two output behaviours are available. In pulse mode the low level ends by itself after a fixed number of timebase ticks (256 ticks, 7.8125 ms, with the defaults). In latch mode the output stays low until software clears the interrupt flag. Software uses a small write port with two registers. It can also request a 30-second adjust. That request bit clears itself after a short timed interval and realigns the sub-second prescaler.

Top module: `rtc_periodic_out`

## Requirements
- R1: The control register sits at `wr_addr`=0. Bit 0 is the mask. While the registered mask is 1, `pin_drive_low` is 0 and events neither start a pulse nor a latch. Writing mask=1 releases the output on the next cycle.
- R2: Control bit 1 selects the mode. With mode=0 (pulse), each unmasked event drives `pin_drive_low` to 1 from the next cycle. It stays at 1 for exactly PULSE_TICKS timebase ticks and then returns to 0 by itself.
- R3: With mode=1 (latch), each unmasked event drives `pin_drive_low` to 1. It stays at 1 until a write to `wr_addr`=1 with bit 0 = 0. Writing that bit as 1 has no effect.
- R4: Control bits 3:2 select the period, counted in ticks since the last phase reset. 00 selects FAST_TICKS (1/64 s). 01 selects SEC_TICKS (1 s). 10 selects SEC_TICKS*MIN_SECS (1 min). 11 selects SEC_TICKS*MIN_SECS*HOUR_MINS (1 h). The same period applies in both modes.
- R5: In pulse mode the low fraction is PULSE_TICKS divided by the period. With the defaults this gives 1/2, 1/128, 1/7680 and 1/460800.
- R6: `irq_flag` is set at every event in either mode, including while masked. A write to `wr_addr`=1 with bit 0 = 0 clears it. When a clear and an event fall in the same cycle, the set wins.
- R7: A write to `wr_addr`=1 with bit 1 = 1 raises `adj_busy` for ADJ_TICKS ticks (at least 125 µs). The tick that ends it resets the sub-second count to zero and issues no event on that tick.
- R8: A control write that changes the mode or the period code resets the whole prescaler phase and releases the output on the next cycle. No shortened pulse results.
- R9: After reset the output is released (`pin_level`=1) and `irq_flag` and `adj_busy` are 0. The control register then reads as mask=0, pulse mode, period 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one cycle per 32.768 kHz period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control, 1 = flag/adjust |
| wr_data | input | 4 | Write data |
| pin_drive_low | output | 1 | Open-drain enable, 1 pulls the pad low |
| pin_level | output | 1 | Pad level with pull-up, inverse of the enable |
| irq_flag | output | 1 | Latched event flag |
| adj_busy | output | 1 | 30-second adjust in progress |

## Verification
The assertions assume that `tick` is a single-cycle enable. They also assume that register writes are one-cycle strobes, so a write and a timebase tick may share a cycle. The hold properties are guarded with "no write" and "no tick", because either one can legally end a low level. The random stimulus asserts `tick` on about three cycles in four and writes registers rarely. It seldom sets the mask and seldom changes the configuration, so long runs of events in each mode, and their interaction with flag clears and adjust requests, are covered. The test uses small prescaler parameters, so an hourly event falls within a few hundred ticks.

// File: rtl/rtc_periodic_out.sv
module rtc_periodic_out #(
  parameter int FAST_TICKS  = 512,
  parameter int SEC_TICKS   = 32768,
  parameter int MIN_SECS    = 60,
  parameter int HOUR_MINS   = 60,
  parameter int PULSE_TICKS = 256,
  parameter int ADJ_TICKS   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [3:0] wr_data,
  output logic       pin_drive_low,
  output logic       pin_level,
  output logic       irq_flag,
  output logic       adj_busy
);
  localparam int FW = $clog2(FAST_TICKS);
  localparam int SW = $clog2(SEC_TICKS);
  localparam int MW = $clog2(MIN_SECS > 1 ? MIN_SECS : 2);
  localparam int HW = $clog2(HOUR_MINS > 1 ? HOUR_MINS : 2);
  localparam int PW = $clog2(PULSE_TICKS + 1);
  localparam int AW = $clog2(ADJ_TICKS + 1);
  localparam logic [FW-1:0] FAST_LAST = FW'(FAST_TICKS - 1);
  localparam logic [SW-1:0] SEC_LAST  = SW'(SEC_TICKS - 1);
  localparam logic [MW-1:0] MIN_LAST  = MW'(MIN_SECS - 1);
  localparam logic [HW-1:0] HOUR_LAST = HW'(HOUR_MINS - 1);

  logic          mask_r, mode_r;
  logic [1:0]    sel_r;
  logic [SW-1:0] sec_cnt;
  logic [MW-1:0] min_cnt;
  logic [HW-1:0] hr_cnt;
  logic [PW-1:0] pulse_cnt;
  logic [AW-1:0] adj_cnt;
  logic          latch_low;

  wire ctl_wr   = wr_en && !wr_addr;
  wire flg_wr   = wr_en && wr_addr;
  wire reconf   = ctl_wr && (wr_data[3:1] != {sel_r, mode_r});
  wire quiet    = ctl_wr && wr_data[0];
  wire adj_done = tick && (adj_cnt == AW'(1));
  wire step     = tick && !reconf && !adj_done;
  wire flag_clr = flg_wr && !wr_data[0];

  wire fast_evt = step && (sec_cnt[FW-1:0] == FAST_LAST);
  wire sec_wrap = step && (sec_cnt == SEC_LAST);
  wire min_wrap = sec_wrap && (min_cnt == MIN_LAST);
  wire hr_wrap  = min_wrap && (hr_cnt == HOUR_LAST);

  logic evt;
  always_comb begin
    case (sel_r)
      2'd0:    evt = fast_evt;
      2'd1:    evt = sec_wrap;
      2'd2:    evt = min_wrap;
      default: evt = hr_wrap;
    endcase
  end

  wire arm = evt && !mask_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_r <= 1'b0;
      mode_r <= 1'b0;
      sel_r  <= 2'd0;
    end else if (ctl_wr) begin
      {sel_r, mode_r, mask_r} <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_cnt <= '0;
      min_cnt <= '0;
      hr_cnt  <= '0;
    end else if (reconf) begin
      sec_cnt <= '0;
      min_cnt <= '0;
      hr_cnt  <= '0;
    end else begin
      if (adj_done)      sec_cnt <= '0;
      else if (step)     sec_cnt <= sec_wrap ? '0 : sec_cnt + 1'b1;
      if (sec_wrap)      min_cnt <= min_wrap ? '0 : min_cnt + 1'b1;
      if (min_wrap)      hr_cnt  <= hr_wrap ? '0 : hr_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pulse_cnt <= '0;
    else if (reconf || quiet)            pulse_cnt <= '0;
    else if (arm && !mode_r)             pulse_cnt <= PW'(PULSE_TICKS);
    else if (tick && pulse_cnt != '0)    pulse_cnt <= pulse_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 latch_low <= 1'b0;
    else if (reconf || quiet)   latch_low <= 1'b0;
    else if (arm && mode_r)     latch_low <= 1'b1;
    else if (flag_clr)          latch_low <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_flag <= 1'b0;
    else if (evt)       irq_flag <= 1'b1;
    else if (flag_clr)  irq_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          adj_cnt <= '0;
    else if (flg_wr && wr_data[1])       adj_cnt <= AW'(ADJ_TICKS);
    else if (tick && adj_cnt != '0)      adj_cnt <= adj_cnt - 1'b1;
  end

  assign pin_drive_low = !mask_r && (latch_low || pulse_cnt != '0);
  assign pin_level     = !pin_drive_low;
  assign adj_busy      = adj_cnt != '0;
endmodule

// File: rtl/rtc_periodic_out_chk.sv
module rtc_periodic_out_chk #(
  parameter int SW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_en,
  input logic          wr_addr,
  input logic [3:0]    wr_data,
  input logic          pin_drive_low,
  input logic          irq_flag,
  input logic          adj_busy,
  input logic          mode_r,
  input logic [1:0]    sel_r,
  input logic [SW-1:0] sec_cnt
);
  assert_mask_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && wr_data[0]) |=> !pin_drive_low);

  assert_pulse_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_r && pin_drive_low && !tick && !wr_en) |=> pin_drive_low);

  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r && pin_drive_low && !wr_en) |=> pin_drive_low);

  assert_low_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_drive_low) |-> irq_flag);

  assert_adj_realign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adj_busy) |-> (sec_cnt == '0));

  assert_reconf_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && (wr_data[3:1] != {sel_r, mode_r}))
      |=> (!pin_drive_low && sec_cnt == '0));
endmodule

bind rtc_periodic_out rtc_periodic_out_chk #(.SW(SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .pin_drive_low(pin_drive_low), .irq_flag(irq_flag),
  .adj_busy(adj_busy), .mode_r(mode_r), .sel_r(sel_r), .sec_cnt(sec_cnt)
);

// File: tb/rtc_periodic_out_tb_top.sv
module rtc_periodic_out_tb_top;
  localparam int FAST = 8, SEC = 32, MINS = 3, HRS = 2, PULSE = 4, ADJ = 5;
  localparam int FULL = SEC * MINS * HRS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0, wr_addr = 1'b0;
  logic [3:0] wr_data = 4'd0;
  logic pin_drive_low, pin_level, irq_flag, adj_busy;

  rtc_periodic_out #(.FAST_TICKS(FAST), .SEC_TICKS(SEC), .MIN_SECS(MINS),
    .HOUR_MINS(HRS), .PULSE_TICKS(PULSE), .ADJ_TICKS(ADJ)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pin_drive_low(pin_drive_low), .pin_level(pin_level),
    .irq_flag(irq_flag), .adj_busy(adj_busy));

  always #10 clk = ~clk;

  int vectors = 0, errors = 0, cycles = 0;
  bit done = 0;

  // Requirement-level model
  bit m_mask, m_mode, m_lt, m_fl;
  bit [1:0] m_sel;
  int ph, m_pl, m_aj;

  function automatic int period_of(bit [1:0] s);
    case (s)
      2'd0: return FAST;
      2'd1: return SEC;
      2'd2: return SEC * MINS;
      default: return FULL;
    endcase
  endfunction

  function automatic bit exp_low();
    return !m_mask && (m_lt || m_pl > 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_mode = 0; m_sel = 0; m_lt = 0; m_fl = 0;
      ph = 0; m_pl = 0; m_aj = 0;
    end else begin
      automatic bit ctl = wr_en && !wr_addr;
      automatic bit flg = wr_en && wr_addr;
      automatic bit rc  = ctl && (wr_data[3:1] != {m_sel, m_mode});
      automatic bit qt  = ctl && wr_data[0];
      automatic bit ad  = tick && (m_aj == 1);
      automatic bit ev  = 0;
      if (rc) ph = 0;
      else if (ad) ph = ph - (ph % SEC);
      else if (tick) begin
        ph = (ph + 1) % FULL;
        ev = (ph % period_of(m_sel)) == 0;
      end
      if (rc || qt) m_pl = 0;
      else if (ev && !m_mask && !m_mode) m_pl = PULSE;
      else if (tick && m_pl > 0) m_pl = m_pl - 1;
      if (rc || qt) m_lt = 0;
      else if (ev && !m_mask && m_mode) m_lt = 1;
      else if (flg && !wr_data[0]) m_lt = 0;
      if (ev) m_fl = 1;
      else if (flg && !wr_data[0]) m_fl = 0;
      if (flg && wr_data[1]) m_aj = ADJ;
      else if (tick && m_aj > 0) m_aj = m_aj - 1;
      if (ctl) {m_sel, m_mode, m_mask} = wr_data;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      automatic string rq = m_mask ? "R1" : (m_mode ? "R3" : "R2");
      check(pin_drive_low == exp_low(), rq, "pin_drive_low", pin_drive_low, exp_low());
      check(pin_level == !exp_low(), "R2", "pin_level", pin_level, !exp_low());
      check(irq_flag == m_fl, "R6", "irq_flag", irq_flag, m_fl);
      check(adj_busy == (m_aj > 0), "R7", "adj_busy", adj_busy, m_aj > 0);
    end
  end

  task automatic drive(bit t, bit we, bit a, bit [3:0] d);
    @(negedge clk);
    #1;
    tick = t; wr_en = we; wr_addr = a; wr_data = d;
  endtask

  task automatic idle_ticks(int n);
    for (int i = 0; i < n; i++) drive(1, 0, 0, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    // R9 reset state
    check(pin_drive_low == 0 && pin_level == 1, "R9", "reset output", pin_drive_low, 0);
    check(irq_flag == 0 && adj_busy == 0, "R9", "reset flags", irq_flag, 0);

    // R5 duty in pulse mode, period 01: 4 events over 4*SEC ticks
    begin
      automatic int lows = 0;
      drive(0, 1, 0, 4'b0100);
      for (int i = 0; i < 4 * SEC + PULSE; i++) begin
        drive(1, 0, 0, 0);
        @(posedge clk); #2;
        if (pin_drive_low) lows++;
      end
      check(lows == 4 * PULSE, "R5", "low cycles at 1 s", lows, 4 * PULSE);
    end

    // R4 period 10: two pulses over 2 minutes of ticks
    begin
      automatic int rises = 0;
      automatic bit prev = 0;
      drive(0, 1, 0, 4'b1000);
      for (int i = 0; i < 2 * SEC * MINS + 1; i++) begin
        drive(1, 0, 0, 0);
        @(posedge clk); #2;
        if (pin_drive_low && !prev) rises++;
        prev = pin_drive_low;
      end
      check(rises == 2, "R4", "events at 1 min code", rises, 2);
    end

    // R3 latch mode, period 00: latch holds, write 1 ignored, write 0 clears
    drive(0, 1, 0, 4'b0010);
    idle_ticks(FAST + 1);
    drive(0, 1, 1, 4'b0001);
    drive(0, 0, 0, 0);
    @(posedge clk); #2;
    check(pin_drive_low == 1, "R3", "latch after write 1", pin_drive_low, 1);
    drive(0, 1, 1, 4'b0000);
    drive(0, 0, 0, 0);
    @(posedge clk); #2;
    check(pin_drive_low == 0 && irq_flag == 0, "R3", "latch cleared", pin_drive_low, 0);

    // R1 mask set: events still flag but output stays released
    drive(0, 1, 0, 4'b0011);
    idle_ticks(2 * FAST);
    @(posedge clk); #2;
    check(pin_drive_low == 0 && irq_flag == 1, "R1", "masked event", pin_drive_low, 0);

    // R8 reconfigure mid-pulse releases at once
    drive(0, 1, 0, 4'b0000);
    idle_ticks(FAST + 1);
    drive(0, 1, 0, 4'b0100);
    drive(0, 0, 0, 0);
    @(posedge clk); #2;
    check(pin_drive_low == 0, "R8", "release on reconf", pin_drive_low, 0);

    // R7 adjust request
    drive(0, 1, 1, 4'b0011);
    drive(0, 0, 0, 0);
    @(posedge clk); #2;
    check(adj_busy == 1, "R7", "adjust started", adj_busy, 1);
    idle_ticks(ADJ);
    drive(0, 0, 0, 0);
    @(posedge clk); #2;
    check(adj_busy == 0, "R7", "adjust ended", adj_busy, 0);

    // Random phase, checked each cycle against the model
    for (int i = 0; i < 30000; i++) begin
      automatic bit t = ($urandom % 4) != 0;
      automatic bit w = ($urandom % 40) == 0;
      automatic bit a = $urandom % 2;
      automatic bit [3:0] d = 4'($urandom);
      if (!a) begin
        d[0] = ($urandom % 6) == 0;
        if (($urandom % 3) != 0) d[3:1] = {m_sel, m_mode};
      end
      drive(t, w, a, d);
    end
    drive(0, 0, 0, 0);
    @(negedge clk);
    finish_run();
  end
endmodule